// File: doc/BRIEF.md
# Receive Word Label Filter and Buffer

This block sits behind a serial avionics-bus receive decoder. Each time the decoder finishes a 32-bit word it pulses a valid strobe with the word, and the block decides whether to keep it. Two independent screens are available: a match of the word's 8-bit label against a 16-entry table, and a match of the two bits that follow the label against two programmed values. A word is kept only when every enabled screen passes. Kept words go into a four-deep first-in first-out buffer. The host empties the buffer one word at a time.

The block drives empty and full flags and an interrupt flag. A configuration bit selects whether the interrupt means "not empty" or "full". On read-out the label byte can be returned in either bit order.

Writing a new configuration flushes the buffer. A separate clear input also flushes it but keeps the configuration. Neither one touches the label table.

Top module: `lblfifo_top`

## Requirements
- R1: The label table has 16 writable entries of 8 bits, each readable back at its address. A label of 00h matches an entry of 00h exactly like any other value.
- R2: Label screening is controlled by config bit 1. When it is 1, a word is kept only if its label equals at least one table entry. When it is 0, every label passes. The label value is formed with incoming word bit 0 as its MSB and bit 7 as its LSB, so the table entry MSB is always compared against the first-received label bit.
- R3: Field screening is controlled by config bit 2. When it is 1, a word is kept only if word bit 9 equals config bit 3 and word bit 8 equals config bit 4.
- R4: A word is stored only if every enabled screen passes. A rejected word leaves the empty, full and interrupt flags unchanged.
- R5: The buffer returns words in arrival order and holds up to 4. The empty flag is 1 at 0 words and the full flag is 1 at 4 words. After reset the buffer is empty.
- R6: A word kept while the buffer is full and no pop occurs replaces the most recently stored entry. The count stays at 4.
- R7: The interrupt flag equals the full flag when config bit 0 is 1, and equals not-empty when config bit 0 is 0.
- R8: A pop on an empty buffer returns all zeros on pop_word and changes no flag.
- R9: pop_word, registered on the pop cycle, carries stored bits 31..8 unchanged in bits 31..8. With config bit 5 = 0 its low byte is the label (stored bit 0 lands in bit 7). With config bit 5 = 1 the low byte is stored bits 7..0 in place.
- R10: A configuration write or a clear pulse empties the buffer in the next cycle. The label table survives both, and the configuration survives the clear pulse.
- R11: A kept word and a pop in the same cycle on a buffer that is neither empty nor full leave the count unchanged. The popped word is the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also zeroes table and config |
| clr | input | 1 | Buffer flush pulse, config kept |
| cfg_wr | input | 1 | Configuration write strobe; flushes buffer |
| cfg_wdata | input | 6 | Config: 0 irq-on-full, 1 label screen, 2 field screen, 3 bit-9 value, 4 bit-8 value, 5 native label order |
| in_vld | input | 1 | Completed word strobe from the decoder |
| in_word | input | 32 | Completed word, bit 0 received first |
| tbl_wr | input | 1 | Label table write strobe |
| tbl_addr | input | 4 | Label table address for write and read |
| tbl_wdata | input | 8 | Label table write value |
| tbl_rdata | output | 8 | Label table entry at tbl_addr |
| pop | input | 1 | Remove the oldest word |
| pop_word | output | 32 | Mapped word from the last pop |
| fifo_empty | output | 1 | Buffer holds no words |
| fifo_full | output | 1 | Buffer holds 4 words |
| fifo_irq | output | 1 | Selectable interrupt flag |

## Verification
A corrupted count or pointer shows up at the flags one cycle after the push or pop that disturbed it. It also shows up as a wrong or out-of-order word at the next pop. A wrong overwrite slot only becomes visible when the buffer is drained after an overflow, as a lost or duplicated word. A bad screen decision shows up one cycle after the strobe, either as a flag that moved when it should not have or as an unexpected word at a later pop. Random traffic mixes labels from inside and outside the table under changing configurations. Directed cases cover overflow, popping an empty buffer and same-cycle push and pop.

// File: rtl/lblfifo_pkg.sv
package lblfifo_pkg;
    localparam int WORD_W = 32;
    localparam int LBL_W  = 8;
    localparam int CFG_W  = 6;

    typedef struct packed {
        logic lbl_native;
        logic dec_b8;
        logic dec_b9;
        logic dec_en;
        logic lbl_en;
        logic irq_on_full;
    } chan_cfg_t;

    function automatic logic [LBL_W-1:0] rev_lbl(input logic [LBL_W-1:0] b);
        logic [LBL_W-1:0] r;
        for (int i = 0; i < LBL_W; i++) r[i] = b[LBL_W-1-i];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] map_out(input logic [WORD_W-1:0] raw,
                                                  input logic native);
        return {raw[WORD_W-1:LBL_W],
                native ? raw[LBL_W-1:0] : rev_lbl(raw[LBL_W-1:0])};
    endfunction
endpackage

// File: rtl/lblfifo_table.sv
module lblfifo_table #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  probe,
    output logic          hit
);
    logic [W-1:0]     ent [DEPTH];
    logic [DEPTH-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst)                              ent[g] <= '0;
                else if (wr && addr == AW'(g))        ent[g] <= wdata;
            end
            assign eq[g] = (ent[g] == probe);
        end
    endgenerate

    assign hit   = |eq;
    assign rdata = ent[addr];
endmodule

// File: rtl/lblfifo_screen.sv
module lblfifo_screen
    import lblfifo_pkg::*;
(
    input  chan_cfg_t   cfg,
    input  logic [1:0]  fld_bits,
    input  logic        tbl_hit,
    output logic        keep
);
    logic lbl_ok;
    logic fld_ok;

    always_comb begin
        lbl_ok = !cfg.lbl_en || tbl_hit;
        fld_ok = !cfg.dec_en || (fld_bits[1] == cfg.dec_b9 && fld_bits[0] == cfg.dec_b8);
        keep   = lbl_ok && fld_ok;
    end
endmodule

// File: rtl/lblfifo_store.sv
module lblfifo_store #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          pop_eff, push_new, push_ovr;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign pop_eff  = pop && !empty;
    assign push_new = push && (!full || pop_eff);
    assign push_ovr = push && full && !pop_eff;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_new)      mem[wr_ptr]      <= wdata;
        else if (push_ovr) mem[prv(wr_ptr)] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_new) wr_ptr <= nxt(wr_ptr);
            if (pop_eff)  rd_ptr <= nxt(rd_ptr);
            case ({push_new, pop_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/lblfifo_top.sv
module lblfifo_top
    import lblfifo_pkg::*;
#(
    parameter int TBL_DEPTH  = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int TAW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    input  logic              tbl_wr,
    input  logic [TAW-1:0]    tbl_addr,
    input  logic [LBL_W-1:0]  tbl_wdata,
    output logic [LBL_W-1:0]  tbl_rdata,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_word,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_irq
);
    chan_cfg_t         cfg_q;
    logic              tbl_hit;
    logic              keep;
    logic              flush;
    logic [WORD_W-1:0] head;

    assign flush = cfg_wr || clr;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= chan_cfg_t'(cfg_wdata);
    end

    lblfifo_table #(.DEPTH(TBL_DEPTH), .W(LBL_W)) tbl_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (tbl_wr),
        .addr  (tbl_addr),
        .wdata (tbl_wdata),
        .rdata (tbl_rdata),
        .probe (rev_lbl(in_word[LBL_W-1:0])),
        .hit   (tbl_hit)
    );

    lblfifo_screen scr_i (
        .cfg      (cfg_q),
        .fld_bits (in_word[LBL_W+1:LBL_W]),
        .tbl_hit  (tbl_hit),
        .keep     (keep)
    );

    lblfifo_store #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush),
        .push  (in_vld && keep),
        .pop   (pop),
        .wdata (in_word),
        .head  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst)      pop_word <= '0;
        else if (pop) pop_word <= fifo_empty ? '0 : map_out(head, cfg_q.lbl_native);
    end

    assign fifo_irq = cfg_q.irq_on_full ? fifo_full : !fifo_empty;
endmodule

// File: rtl/lblfifo_chk.sv
module lblfifo_chk (
    input logic        clk,
    input logic        rst,
    input logic        clr,
    input logic        cfg_wr,
    input logic        in_vld,
    input logic        pop,
    input logic        keep,
    input logic        tbl_hit,
    input logic        lbl_en,
    input logic [31:0] pop_word,
    input logic        fifo_empty,
    input logic        fifo_full
);
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_empty && fifo_full));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || clr) |=> fifo_empty);

    a_r8_pop_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (pop && fifo_empty) |=> (pop_word == 32'h0));

    a_r4_reject_no_flag: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !keep && !pop && !cfg_wr && !clr)
        |=> ($stable(fifo_empty) && $stable(fifo_full)));

    a_r2_miss_dropped: assert property (@(posedge clk) disable iff (rst)
        (in_vld && lbl_en && !tbl_hit && !pop && !cfg_wr && !clr)
        |=> $stable(fifo_empty));

    a_r6_full_stays_full: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && in_vld && keep && !pop && !cfg_wr && !clr) |=> fifo_full);

    a_r11_pushpop_steady: assert property (@(posedge clk) disable iff (rst)
        (in_vld && keep && pop && !fifo_empty && !fifo_full && !cfg_wr && !clr)
        |=> (!fifo_empty && !fifo_full));
endmodule

bind lblfifo_top lblfifo_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .cfg_wr     (cfg_wr),
    .in_vld     (in_vld),
    .pop        (pop),
    .keep       (keep),
    .tbl_hit    (tbl_hit),
    .lbl_en     (cfg_q.lbl_en),
    .pop_word   (pop_word),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
);

// File: tb/lblfifo_tb.sv
module lblfifo_top_tb_top;
    logic        clk = 0;
    logic        rst, clr, cfg_wr, in_vld, tbl_wr, pop;
    logic [5:0]  cfg_wdata;
    logic [31:0] in_word;
    logic [3:0]  tbl_addr;
    logic [7:0]  tbl_wdata, tbl_rdata;
    logic [31:0] pop_word;
    logic        fifo_empty, fifo_full, fifo_irq;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] mq [4];
    int          mcnt;
    logic [5:0]  mcfg;
    logic [7:0]  mtbl [16];

    always #5 clk = ~clk;

    lblfifo_top dut_i (
        .clk(clk), .rst(rst), .clr(clr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .in_vld(in_vld), .in_word(in_word), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .pop(pop), .pop_word(pop_word),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_irq(fifo_irq)
    );

    function automatic logic [7:0] rv(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [31:0] mkw(input logic [7:0] lbl, input bit b9,
                                        input bit b8, input logic [21:0] up);
        return {up, b9, b8, rv(lbl)};
    endfunction

    function automatic bit m_keep(input logic [31:0] w);
        bit hit = 0;
        for (int i = 0; i < 16; i++) if (mtbl[i] == rv(w[7:0])) hit = 1;
        if (mcfg[1] && !hit) return 0;
        if (mcfg[2] && (w[9] != mcfg[3] || w[8] != mcfg[4])) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] m_map(input logic [31:0] w);
        return {w[31:8], mcfg[5] ? w[7:0] : rv(w[7:0])};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit iv, input logic [31:0] w, input bit p,
                       input bit cw, input logic [5:0] cv, input bit mc,
                       input bit tw, input logic [3:0] ta, input logic [7:0] td,
                       input string tag);
        logic [31:0] exp_pop;
        bit          e, f;
        @(negedge clk);
        in_vld = iv; in_word = w; pop = p; cfg_wr = cw; cfg_wdata = cv; clr = mc;
        tbl_wr = tw; tbl_addr = ta; tbl_wdata = td;
        exp_pop = (mcnt == 0) ? 32'h0 : m_map(mq[0]);
        if (cw || mc) begin
            mcnt = 0;
            if (cw) mcfg = cv;
        end else begin
            bit k = iv && m_keep(w);
            if (p && mcnt > 0) begin
                for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
                mcnt--;
            end
            if (k) begin
                if (mcnt < 4) begin mq[mcnt] = w; mcnt++; end
                else mq[3] = w;
            end
        end
        if (tw) mtbl[ta] = td;
        @(posedge clk);
        #1;
        e = (mcnt == 0);
        f = (mcnt == 4);
        chk({tag, " empty"}, 32'(fifo_empty), 32'(e));
        chk({tag, " full"}, 32'(fifo_full), 32'(f));
        chk({tag, " R7 irq"}, 32'(fifo_irq), 32'(mcfg[0] ? f : !e));
        if (p) chk({tag, " pop_word"}, pop_word, exp_pop);
        chk({tag, " R1 table read"}, 32'(tbl_rdata), 32'(mtbl[ta]));
        in_vld = 0; pop = 0; cfg_wr = 0; clr = 0; tbl_wr = 0;
    endtask

    task automatic push_w(input logic [31:0] w, input string tag);
        cyc(1, w, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic pop_w(input string tag);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic set_cfg(input logic [5:0] cv, input string tag);
        cyc(0, 0, 0, 1, cv, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; clr = 0; cfg_wr = 0; cfg_wdata = 0; in_vld = 0; in_word = 0;
        tbl_wr = 0; tbl_addr = 0; tbl_wdata = 0; pop = 0;
        mcnt = 0; mcfg = 0;
        for (int i = 0; i < 16; i++) mtbl[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R5 reset empty", 32'(fifo_empty), 32'd1);
        chk("R5 reset full", 32'(fifo_full), 32'd0);
        chk("R5 reset irq", 32'(fifo_irq), 32'd0);

        // R1: table load, 00h and two real labels, rest duplicated
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v = (i == 0) ? 8'h00 : (i == 1) ? 8'hA5 : 8'h3C;
            cyc(0, 0, 0, 0, 0, 0, 1, 4'(i), v, "R1 load");
        end

        // R2: label screen on
        set_cfg(6'b000010, "R2 cfg");
        push_w(mkw(8'h00, 0, 0, 22'h12345), "R1 zero label kept");
        push_w(mkw(8'h11, 0, 0, 22'h0abcd), "R2 miss dropped");
        push_w(mkw(8'hA5, 1, 0, 22'h3ffff), "R2 hit kept");
        pop_w("R9 reversed label");
        pop_w("R5 order");
        // R9 native order
        set_cfg(6'b100000, "R9 cfg");
        push_w(mkw(8'h81, 1, 1, 22'h15555), "R2 disabled passes");
        pop_w("R9 native label");

        // R3: field screen, bit9=1 bit8=0
        set_cfg(6'b001100, "R3 cfg");
        push_w(mkw(8'h11, 0, 1, 22'h1), "R3 mismatch dropped");
        push_w(mkw(8'h11, 1, 0, 22'h2), "R3 match kept");
        // R4: both screens
        set_cfg(6'b001110, "R4 cfg");
        push_w(mkw(8'h11, 1, 0, 22'h3), "R4 label fails");
        push_w(mkw(8'h3C, 0, 0, 22'h4), "R4 field fails");
        push_w(mkw(8'h3C, 1, 0, 22'h5), "R4 both pass");
        pop_w("R4 pop");

        // R6: overflow, R7 irq on full
        set_cfg(6'b000001, "R7 cfg");
        for (int i = 0; i < 6; i++) push_w(mkw(8'h40, 0, 0, 22'(i + 16)), "R6 fill");
        for (int i = 0; i < 4; i++) pop_w("R6 drain");
        pop_w("R8 pop empty");
        pop_w("R8 pop empty again");

        // R11: push and pop together
        push_w(mkw(8'h01, 0, 0, 22'h7), "R11 pre");
        push_w(mkw(8'h02, 0, 0, 22'h8), "R11 pre");
        cyc(1, mkw(8'h03, 0, 0, 22'h9), 1, 0, 0, 0, 0, 0, 0, "R11 push+pop");
        pop_w("R11 drain");
        pop_w("R11 drain");

        // R10: clear keeps config and table, cfg write flushes
        set_cfg(6'b000010, "R10 cfg");
        push_w(mkw(8'hA5, 0, 0, 22'h1), "R10 fill");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 clear");
        push_w(mkw(8'h77, 0, 0, 22'h1), "R10 cfg kept after clear");
        push_w(mkw(8'h3C, 0, 0, 22'h1), "R10 table kept");
        set_cfg(6'b000010, "R10 cfg write flush");
        cyc(0, 0, 0, 0, 0, 0, 0, 4'd1, 0, "R10 table kept read");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) set_cfg(6'($urandom), "RND cfg");
            else if (r < 5) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "RND clear");
            else if (r < 7) cyc(0, 0, 0, 0, 0, 0, 1, 4'($urandom), 8'($urandom), "RND tbl");
            else begin
                logic [7:0] l = ($urandom_range(0, 1) == 1) ? mtbl[$urandom_range(0, 15)]
                                                           : 8'($urandom);
                cyc($urandom_range(0, 2) != 0,
                    mkw(l, 1'($urandom), 1'($urandom), 22'($urandom)),
                    $urandom_range(0, 2) == 0, 0, 0, 0, 0, 4'($urandom), 0, "RND");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule